// File: doc/BRIEF.md
# BCD to seven-segment decoder

This block turns a four-bit code into the drive pattern for one seven-segment digit wired as common anode. Codes zero through nine produce the usual decimal numerals. The six codes above nine are not left as don't-cares. Codes ten to fourteen each light a fixed partial shape, so that an out-of-range value is visible and can be told apart. Code fifteen turns the whole digit off.

The block is purely combinational and has no clock. A segment output follows its inputs with no cycle of latency. An active-high blank input forces every segment dark whatever the code. The decimal-point drive is held in its unlit state.

Segment vectors in this block use one fixed bit order: bit 6 is segment a, bit 5 is b, bit 4 is c, bit 3 is d, bit 2 is e, bit 1 is f and bit 0 is g. On the output port a 0 lights the segment and a 1 leaves it dark.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With blank low, codes 0 to 4 give seg_n_o (a..g, 0 = lit) of 0000001, 1001111, 0010010, 0000110 and 1001100.
- R2: With blank low, codes 5 to 9 give seg_n_o of 0100100, 0100000, 0001111, 0000000 and 0000100.
- R3: With blank low, code 10 lights only d, e and g. Code 11 lights only c, d and g. Code 12 lights only b, f and g.
- R4: With blank low, code 13 lights only a, d, f and g. Code 14 lights only d, e, f and g.
- R5: With blank low, code 15 leaves all seven segments dark (seg_n_o = 1111111).
- R6: With blank high, seg_n_o is 1111111 for every one of the 16 codes.
- R7: dp_n_o is 1 (dark) for every code and for either blank value.
- R8: Every code from 0 to 14 lights at least one segment while blank is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 4 | Input code, bit 3 most significant |
| blank_i | input | 1 | Active-high forced blank of all segments |
| seg_n_o | output | 7 | Active-low segment drives, bit 6 = a down to bit 0 = g |
| dp_n_o | output | 1 | Active-low decimal-point drive, held dark |

## Verification
The block holds no state, so a fault in the glyph lookup shows on seg_n_o for the code that selects the faulty entry, in the same settle time as the input change. A fault in the blanking or polarity stage shows on every code at once. For that reason all sixteen codes are applied with blank low and again with blank high. Each result is compared bit by bit against a table built from the requirements. This exposes a single wrong segment, a pair of swapped codes, or a blank that leaks through for only some codes.

// File: rtl/seg_glyph_pkg.sv
package seg_glyph_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SEG_COUNT = 7;
  localparam int unsigned CODE_NUM  = 1 << CODE_W;

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [SEG_COUNT-1:0] seg_mask_t;

  localparam seg_mask_t SEG_NONE = '0;

endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
  import seg_glyph_pkg::*;
(
  input  code_t     code_i,
  output seg_mask_t lit_o
);

  // Active-high lit mask, bit 6 = a ... bit 0 = g.
  always_comb begin
    unique case (code_i)
      4'd0:    lit_o = 7'b1111110;
      4'd1:    lit_o = 7'b0110000;
      4'd2:    lit_o = 7'b1101101;
      4'd3:    lit_o = 7'b1111001;
      4'd4:    lit_o = 7'b0110011;
      4'd5:    lit_o = 7'b1011011;
      4'd6:    lit_o = 7'b1011111;
      4'd7:    lit_o = 7'b1110000;
      4'd8:    lit_o = 7'b1111111;
      4'd9:    lit_o = 7'b1111011;
      4'd10:   lit_o = 7'b0001101;
      4'd11:   lit_o = 7'b0011001;
      4'd12:   lit_o = 7'b0100011;
      4'd13:   lit_o = 7'b1001011;
      4'd14:   lit_o = 7'b0001111;
      default: lit_o = SEG_NONE;
    endcase
  end

endmodule

// File: rtl/seg_drive_stage.sv
module seg_drive_stage
  import seg_glyph_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  seg_mask_t lit_i,
  input  logic      blank_i,
  output seg_mask_t seg_o,
  output logic      dp_o
);

  seg_mask_t gated;

  always_comb begin
    gated = blank_i ? SEG_NONE : lit_i;
  end

  generate
    if (ACTIVE_LOW) begin : g_sink
      assign seg_o = ~gated;
      assign dp_o  = 1'b1;
    end else begin : g_source
      assign seg_o = gated;
      assign dp_o  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import seg_glyph_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [3:0] code_i,
  input  logic       blank_i,
  output logic [6:0] seg_n_o,
  output logic       dp_n_o
);

  seg_mask_t lit;

  seg_glyph_rom u_rom (
    .code_i (code_i),
    .lit_o  (lit)
  );

  seg_drive_stage #(
    .ACTIVE_LOW (ACTIVE_LOW)
  ) u_drive (
    .lit_i   (lit),
    .blank_i (blank_i),
    .seg_o   (seg_n_o),
    .dp_o    (dp_n_o)
  );

endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk (
  input logic [3:0] code_i,
  input logic       blank_i,
  input logic [6:0] seg_n_o,
  input logic       dp_n_o
);

  always_comb begin
    if (!$isunknown({code_i, blank_i})) begin
      AST_BLANK_DARK: assert (!blank_i || seg_n_o == 7'h7F); // R6
      AST_DP_DARK: assert (dp_n_o == 1'b1); // R7
      AST_CODE15_DARK: assert (blank_i || code_i != 4'd15 || seg_n_o == 7'h7F); // R5
      AST_GLYPH_VISIBLE: assert (blank_i || code_i == 4'd15 || seg_n_o != 7'h7F); // R8
      AST_ONE_TWO_SEGS: assert (blank_i || code_i != 4'd1 || $countones(~seg_n_o) == 2); // R1
      AST_EIGHT_FULL: assert (blank_i || code_i != 4'd8 || seg_n_o == 7'h00); // R2
      AST_HIGH_CODES_G: assert (blank_i || code_i < 4'd10 || code_i == 4'd15 || !seg_n_o[0]); // R3
    end
  end

endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
  .code_i  (code_i),
  .blank_i (blank_i),
  .seg_n_o (seg_n_o),
  .dp_n_o  (dp_n_o)
);

// File: tb/bcd_seg_decoder_bench.sv
module bcd_seg_decoder_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] code;
  logic       blank;
  logic [6:0] seg_n;
  logic       dp_n;
  int         n_run;
  int         n_fail;
  bit         done;

  bcd_seg_decoder u_bcd_seg_decoder (
    .code_i  (code),
    .blank_i (blank),
    .seg_n_o (seg_n),
    .dp_n_o  (dp_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected active-high lit mask (a..g) taken from the requirements.
  function automatic logic [6:0] want_lit(input int c);
    case (c)
      0:  return 7'b1111110;
      1:  return 7'b0110000;
      2:  return 7'b1101101;
      3:  return 7'b1111001;
      4:  return 7'b0110011;
      5:  return 7'b1011011;
      6:  return 7'b1011111;
      7:  return 7'b1110000;
      8:  return 7'b1111111;
      9:  return 7'b1111011;
      10: return 7'b0001101; // d e g
      11: return 7'b0011001; // c d g
      12: return 7'b0100011; // b f g
      13: return 7'b1001011; // a d f g
      14: return 7'b0001111; // d e f g
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input int c, input logic b);
    @(posedge clk);
    code  = c[3:0];
    blank = b;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    apply(0, 1'b1);
    check("R6 after reset", {seg_n, dp_n}, 8'hFF);
  endtask

  task automatic t_digits_low;
    for (int c = 0; c <= 4; c++) begin
      apply(c, 1'b0);
      check("R1 digit", {1'b0, seg_n}, {1'b0, ~want_lit(c)});
    end
  endtask

  task automatic t_digits_high;
    for (int c = 5; c <= 9; c++) begin
      apply(c, 1'b0);
      check("R2 digit", {1'b0, seg_n}, {1'b0, ~want_lit(c)});
    end
  endtask

  task automatic t_partial_a;
    for (int c = 10; c <= 12; c++) begin
      apply(c, 1'b0);
      check("R3 glyph", {1'b0, seg_n}, {1'b0, ~want_lit(c)});
    end
  endtask

  task automatic t_partial_b;
    for (int c = 13; c <= 14; c++) begin
      apply(c, 1'b0);
      check("R4 glyph", {1'b0, seg_n}, {1'b0, ~want_lit(c)});
    end
  endtask

  task automatic t_code15;
    apply(15, 1'b0);
    check("R5 code 15 dark", {1'b0, seg_n}, 8'h7F);
  endtask

  task automatic t_blank_all;
    for (int c = 0; c < 16; c++) begin
      apply(c, 1'b1);
      check("R6 blank", {1'b0, seg_n}, 8'h7F);
    end
  endtask

  task automatic t_dp_and_visible;
    for (int c = 0; c < 16; c++) begin
      apply(c, c[0]);
      check("R7 dp dark", {7'd0, dp_n}, 8'h01);
      if (c < 15) begin
        apply(c, 1'b0);
        check("R8 visible", {7'd0, seg_n != 7'h7F}, 8'h01);
      end
    end
  endtask

  task automatic t_blank_release;
    apply(8, 1'b1);
    check("R6 blank on 8", {1'b0, seg_n}, 8'h7F);
    apply(8, 1'b0);
    check("R2 after unblank", {1'b0, seg_n}, 8'h00);
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    code   = 4'd0;
    blank  = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_digits_low();
    t_digits_high();
    t_partial_a();
    t_partial_b();
    t_code15();
    t_blank_all();
    t_dp_and_visible();
    t_blank_release();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule